// File: doc/BRIEF.md
# Dual-Issue Structural Hazard Scoreboard

This block sits at the dispatch point of a two-wide in-order front end. Each cycle it receives up to two decoded instruction class codes. Slot 0 is the older instruction and slot 1 the younger. The block decides which of them may issue that cycle, given the execution units they need and the units that are still occupied. For units that exist more than once, such as the ALUs and the floating-point units, it reports which instance each issued instruction claims. It also raises a stall so the front end holds any instruction that was not accepted.

The block has no datapath. It models only structural occupancy. Most units are pipelined and are claimed only in the issue cycle. The extended-arithmetic module, the third FPU (divide and square root) and the issue slots themselves (block move) are held for several cycles by down-counters. Operand readiness and register dependencies are left to other logic.

Top module: `dual_issue_hazard_sb`

## Requirements
- R1: A synchronous reset clears every busy counter. In the first cycle after reset, any single valid instruction in slot 0 issues.
- R2: Issue is in order. `issue0` is high only when `valid0` is high. `issue1` is high only when `valid1` and `issue0` are both high.
- R3: Class 3 (ALU) may issue in both slots in the same cycle. Slot 0 then reports unit 0 and slot 1 reports unit 1. A lone ALU op reports unit 0.
- R4: The single-instance units are move (class 2), branch (4), memory write (5), memory read (6) and FP compare (14). If the younger instruction needs the same unit as the older one, the younger does not issue that cycle.
- R5: The extended-arithmetic port is used by classes 7 (write) and 13 (FP register read), and also by classes 8, 9, 10, 11 and 12. Two users of the port cannot issue together. Classes 7 and 13 do not occupy the arithmetic module, so a multiply may issue in the next cycle.
- R6: Classes 8 (read), 9 (64-bit shift), 10 (multiply), 11 (divide) and 12 (double divide) claim the arithmetic module. After issue, the module stays busy for 0, 1, 2, 33 and 65 further cycles respectively. A module user in either slot waits until the module is free.
- R7: The FP classes use one FPU each, and the unit index names that FPU: 15 (move or convert) uses FPU 0, 16 (arithmetic) uses FPU 1, 17 (divide or square root) uses FPU 2, and 18 (integer-to-FP write) uses FPU 3. FPU 2 stays busy for 14 further cycles after a class 17 issues.
- R8: Class 19 (block move) issues only from slot 0. The younger instruction is blocked in that cycle, and nothing issues in the 15 cycles that follow. A block move in slot 1 never issues.
- R9: `stall` is high exactly when some valid instruction is not issued in that cycle.
- R10: Classes 0 (no-op), 1 (barrier) and 20 to 31 (unassigned) use only an issue slot. Two such instructions issue together.
- R11: A unit index output is 0 when its slot does not issue, and 0 for every class that is not an ALU or FP class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid0 | input | 1 | Older slot holds an instruction |
| cls0 | input | 5 | Class code of the older instruction |
| valid1 | input | 1 | Younger slot holds an instruction |
| cls1 | input | 5 | Class code of the younger instruction |
| issue0 | output | 1 | Older instruction accepted this cycle |
| issue1 | output | 1 | Younger instruction accepted this cycle |
| unit0 | output | 2 | Instance claimed by the older instruction |
| unit1 | output | 2 | Instance claimed by the younger instruction |
| stall | output | 1 | Front end must hold its unaccepted instructions |

## Verification
The hardest situation to reach from the ports is the exact end of a long occupancy window, in particular the 65-cycle double divide and the 15-cycle block-move hold. A one-cycle error there shows up only if a competing instruction is presented at that moment. The bench issues each long-latency class once. It then holds a competing instruction in slot 0 and counts the rejected cycles until it is accepted, and compares that count with the stated hold length. All pairs of class codes are also swept from a freshly reset state, so that every same-cycle conflict is covered.

// File: rtl/sb_pkg.sv
package sb_pkg;
   localparam int CLS_W = 5;
   localparam int NRES  = 11;
   localparam int IDX_W = 2;

   typedef enum logic [CLS_W-1:0] {
      CL_NOP    = 5'd0,
      CL_BARR   = 5'd1,
      CL_IMOV   = 5'd2,
      CL_ALU    = 5'd3,
      CL_BR     = 5'd4,
      CL_STORE  = 5'd5,
      CL_LOAD   = 5'd6,
      CL_XWR    = 5'd7,
      CL_XRD    = 5'd8,
      CL_SHL64  = 5'd9,
      CL_MUL    = 5'd10,
      CL_DIV    = 5'd11,
      CL_DDIV   = 5'd12,
      CL_FPRD   = 5'd13,
      CL_FCMP   = 5'd14,
      CL_FMOVE  = 5'd15,
      CL_FARITH = 5'd16,
      CL_FDIV   = 5'd17,
      CL_FWR    = 5'd18,
      CL_BLK    = 5'd19
   } cls_e;

   localparam int RS_MOV   = 0;
   localparam int RS_BRU   = 1;
   localparam int RS_MWR   = 2;
   localparam int RS_MRD   = 3;
   localparam int RS_XPORT = 4;
   localparam int RS_XMOD  = 5;
   localparam int RS_FCMP  = 6;
   localparam int RS_FPU0  = 7;
   localparam int RS_FPU1  = 8;
   localparam int RS_FPU2  = 9;
   localparam int RS_FPU3  = 10;

   typedef struct packed {
      logic [NRES-1:0]  res;
      logic             alu;
      logic             blk;
      logic [IDX_W-1:0] idx;
   } need_t;
endpackage

// File: rtl/sb_class_decode.sv
module sb_class_decode
   import sb_pkg::*;
#(
   parameter int SHIFT_EXTRA = 1,
   parameter int MUL_EXTRA   = 2,
   parameter int DIV_EXTRA   = 33,
   parameter int DDIV_EXTRA  = 65,
   parameter int FDIV_EXTRA  = 14,
   parameter int CNT_W       = 7
) (
   input  logic [CLS_W-1:0] cls,
   output need_t            need,
   output logic [CNT_W-1:0] xmod_hold,
   output logic [CNT_W-1:0] fdiv_hold
);
   always_comb begin
      need      = '0;
      xmod_hold = '0;
      fdiv_hold = '0;
      case (cls_e'(cls))
         CL_IMOV:   need.res[RS_MOV]  = 1'b1;
         CL_ALU:    need.alu          = 1'b1;
         CL_BR:     need.res[RS_BRU]  = 1'b1;
         CL_STORE:  need.res[RS_MWR]  = 1'b1;
         CL_LOAD:   need.res[RS_MRD]  = 1'b1;
         CL_XWR,
         CL_FPRD:   need.res[RS_XPORT] = 1'b1;
         CL_XRD: begin
            need.res[RS_XPORT] = 1'b1;
            need.res[RS_XMOD]  = 1'b1;
         end
         CL_SHL64: begin
            need.res[RS_XPORT] = 1'b1;
            need.res[RS_XMOD]  = 1'b1;
            xmod_hold = CNT_W'(SHIFT_EXTRA);
         end
         CL_MUL: begin
            need.res[RS_XPORT] = 1'b1;
            need.res[RS_XMOD]  = 1'b1;
            xmod_hold = CNT_W'(MUL_EXTRA);
         end
         CL_DIV: begin
            need.res[RS_XPORT] = 1'b1;
            need.res[RS_XMOD]  = 1'b1;
            xmod_hold = CNT_W'(DIV_EXTRA);
         end
         CL_DDIV: begin
            need.res[RS_XPORT] = 1'b1;
            need.res[RS_XMOD]  = 1'b1;
            xmod_hold = CNT_W'(DDIV_EXTRA);
         end
         CL_FCMP:   need.res[RS_FCMP] = 1'b1;
         CL_FMOVE: begin
            need.res[RS_FPU0] = 1'b1;
            need.idx = IDX_W'(0);
         end
         CL_FARITH: begin
            need.res[RS_FPU1] = 1'b1;
            need.idx = IDX_W'(1);
         end
         CL_FDIV: begin
            need.res[RS_FPU2] = 1'b1;
            need.idx = IDX_W'(2);
            fdiv_hold = CNT_W'(FDIV_EXTRA);
         end
         CL_FWR: begin
            need.res[RS_FPU3] = 1'b1;
            need.idx = IDX_W'(3);
         end
         CL_BLK:    need.blk = 1'b1;
         default:   need = '0;
      endcase
   end
endmodule

// File: rtl/sb_busy_counter.sv
module sb_busy_counter #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)               cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   p_load_free_r6: assert property (@(posedge clk) disable iff (rst)
      load |-> !busy);
   p_idle_stays_r1: assert property (@(posedge clk) disable iff (rst)
      (!busy && !load) |=> !busy);
   p_count_down_r6: assert property (@(posedge clk) disable iff (rst)
      (busy && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/dual_issue_hazard_sb.sv
module dual_issue_hazard_sb
   import sb_pkg::*;
#(
   parameter int ALU_COUNT   = 2,
   parameter int SHIFT_EXTRA = 1,
   parameter int MUL_EXTRA   = 2,
   parameter int DIV_EXTRA   = 33,
   parameter int DDIV_EXTRA  = 65,
   parameter int FDIV_EXTRA  = 14,
   parameter int BLK_CYCLES  = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             valid0,
   input  logic [4:0]       cls0,
   input  logic             valid1,
   input  logic [4:0]       cls1,
   output logic             issue0,
   output logic             issue1,
   output logic [1:0]       unit0,
   output logic [1:0]       unit1,
   output logic             stall
);
   localparam int M1      = (DDIV_EXTRA > DIV_EXTRA) ? DDIV_EXTRA : DIV_EXTRA;
   localparam int M2      = (M1 > FDIV_EXTRA) ? M1 : FDIV_EXTRA;
   localparam int MAXHOLD = (M2 > BLK_CYCLES) ? M2 : BLK_CYCLES;
   localparam int CNT_W   = $clog2(MAXHOLD + 1);

   generate
      if (ALU_COUNT < 1 || ALU_COUNT > 2) begin : g_bad_alu
         $error("ALU_COUNT must be 1 or 2");
      end
      if (BLK_CYCLES < 2) begin : g_bad_blk
         $error("BLK_CYCLES must be at least 2");
      end
      if (SHIFT_EXTRA < 0 || MUL_EXTRA < 0 || DIV_EXTRA < 0 ||
          DDIV_EXTRA < 0 || FDIV_EXTRA < 0) begin : g_bad_hold
         $error("hold lengths must be non-negative");
      end
   endgenerate

   logic [CLS_W-1:0] cls_a [2];
   need_t            need  [2];
   logic [CNT_W-1:0] xh    [2];
   logic [CNT_W-1:0] fh    [2];

   assign cls_a[0] = cls0;
   assign cls_a[1] = cls1;

   for (genvar s = 0; s < 2; s++) begin : g_dec
      sb_class_decode #(
         .SHIFT_EXTRA(SHIFT_EXTRA), .MUL_EXTRA(MUL_EXTRA),
         .DIV_EXTRA(DIV_EXTRA), .DDIV_EXTRA(DDIV_EXTRA),
         .FDIV_EXTRA(FDIV_EXTRA), .CNT_W(CNT_W)
      ) u_dec (
         .cls(cls_a[s]), .need(need[s]), .xmod_hold(xh[s]), .fdiv_hold(fh[s])
      );
   end

   logic xmod_busy, fdiv_busy, blk_busy;
   logic alu_pair_ok;

   generate
      if (ALU_COUNT >= 2) begin : g_two_alu
         assign alu_pair_ok = 1'b1;
      end else begin : g_one_alu
         assign alu_pair_ok = 1'b0;
      end
   endgenerate

   logic unit_free0, unit_free1, pair_ok;

   assign unit_free0 = !(need[0].res[RS_XMOD] && xmod_busy) &&
                       !(need[0].res[RS_FPU2] && fdiv_busy);
   assign unit_free1 = !(need[1].res[RS_XMOD] && xmod_busy) &&
                       !(need[1].res[RS_FPU2] && fdiv_busy);
   assign pair_ok    = ((need[0].res & need[1].res) == '0) &&
                       !need[0].blk && !need[1].blk &&
                       !(need[0].alu && need[1].alu && !alu_pair_ok);

   assign issue0 = valid0 && !blk_busy && unit_free0;
   assign issue1 = valid1 && issue0 && unit_free1 && pair_ok;
   assign stall  = (valid0 && !issue0) || (valid1 && !issue1);

   assign unit0 = issue0 ? need[0].idx : '0;
   assign unit1 = !issue1                       ? '0 :
                  (need[0].alu && need[1].alu)  ? IDX_W'(1) : need[1].idx;

   logic             xmod_ld, fdiv_ld, blk_ld;
   logic [CNT_W-1:0] xmod_val, fdiv_val;

   assign xmod_ld  = (issue0 && need[0].res[RS_XMOD]) || (issue1 && need[1].res[RS_XMOD]);
   assign xmod_val = (issue0 && need[0].res[RS_XMOD]) ? xh[0] : xh[1];
   assign fdiv_ld  = (issue0 && need[0].res[RS_FPU2]) || (issue1 && need[1].res[RS_FPU2]);
   assign fdiv_val = (issue0 && need[0].res[RS_FPU2]) ? fh[0] : fh[1];
   assign blk_ld   = issue0 && need[0].blk;

   sb_busy_counter #(.CNT_W(CNT_W)) u_xmod (
      .clk(clk), .rst(rst), .load(xmod_ld), .load_val(xmod_val), .busy(xmod_busy));
   sb_busy_counter #(.CNT_W(CNT_W)) u_fdiv (
      .clk(clk), .rst(rst), .load(fdiv_ld), .load_val(fdiv_val), .busy(fdiv_busy));
   sb_busy_counter #(.CNT_W(CNT_W)) u_blk (
      .clk(clk), .rst(rst), .load(blk_ld), .load_val(CNT_W'(BLK_CYCLES - 1)),
      .busy(blk_busy));

   p_in_order_r2: assert property (@(posedge clk) disable iff (rst)
      issue1 |-> (issue0 && valid1));
   p_alu_split_r3: assert property (@(posedge clk) disable iff (rst)
      (issue1 && need[0].alu && need[1].alu) |-> (unit0 != unit1));
   p_no_shared_unit_r4: assert property (@(posedge clk) disable iff (rst)
      (issue0 && issue1) |-> ((need[0].res & need[1].res) == '0));
   p_xmod_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (issue0 && cls_e'(cls0) == CL_MUL) |=> !(issue0 && need[0].res[RS_XMOD]));
   p_fdiv_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (issue0 && cls_e'(cls0) == CL_FDIV) |=> !(issue0 && need[0].res[RS_FPU2]));
   p_blk_alone_r8: assert property (@(posedge clk) disable iff (rst)
      (issue0 && need[0].blk) |-> !issue1);
   p_blk_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (issue0 && need[0].blk) |=> (!issue0 && !issue1));
   p_stall_r9: assert property (@(posedge clk) disable iff (rst)
      (valid0 && !issue0) |-> stall);
endmodule

// File: tb/sim_dual_issue_hazard_sb.sv
module sim_dual_issue_hazard_sb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       valid0 = 1'b0, valid1 = 1'b0;
   logic [4:0] cls0 = '0, cls1 = '0;
   logic       issue0, issue1, stall;
   logic [1:0] unit0, unit1;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   dual_issue_hazard_sb u0 (
      .clk(clk), .rst(rst), .valid0(valid0), .cls0(cls0), .valid1(valid1),
      .cls1(cls1), .issue0(issue0), .issue1(issue1), .unit0(unit0),
      .unit1(unit1), .stall(stall));

   // resource usage in the bench's own bit order
   function automatic logic [11:0] uses(input int c);
      case (c)
         2:  return 12'h001;
         4:  return 12'h002;
         5:  return 12'h004;
         6:  return 12'h008;
         7, 13: return 12'h010;
         8, 9, 10, 11, 12: return 12'h030;
         14: return 12'h040;
         15: return 12'h080;
         16: return 12'h100;
         17: return 12'h200;
         18: return 12'h400;
         default: return 12'h000;
      endcase
   endfunction

   function automatic logic [1:0] fidx(input int c);
      return (c >= 15 && c <= 18) ? 2'(c - 15) : 2'd0;
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; valid0 = 1'b0; valid1 = 1'b0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   // issue first, then hold probe in slot 0 and count rejected cycles
   task automatic window(input int first, input int probe, input int exp_wait, input string tag);
      int waited;
      do_reset();
      valid0 = 1'b1; cls0 = 5'(first);
      #2 chk(32'(issue0), 1, {tag, " first issues"});
      @(negedge clk);
      cls0 = 5'(probe);
      waited = 0;
      #2;
      while (!issue0 && waited < 300) begin
         chk(32'(stall), 1, "R9 stall while held");
         waited++;
         @(negedge clk);
         #2;
      end
      chk(32'(waited), 32'(exp_wait), {tag, " hold length"});
      @(negedge clk);
      valid0 = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 reset state: nothing valid, nothing issued
      do_reset();
      #2;
      chk(32'(issue0), 0, "R2 no issue without valid");
      chk(32'(stall), 0, "R9 idle no stall");
      // R2 younger alone cannot issue
      valid1 = 1'b1; cls1 = 5'd0;
      #1 chk(32'(issue1), 0, "R2 younger without older");
      chk(32'(stall), 1, "R9 younger held");

      // R3 R4 R5 R7 R8 R10 R11 all class pairs from a fresh state
      for (int a = 0; a < 32; a++) begin
         for (int b = 0; b < 32; b++) begin
            logic e1;
            logic [1:0] eu1;
            do_reset();
            valid0 = 1'b1; cls0 = 5'(a);
            valid1 = 1'b1; cls1 = 5'(b);
            e1 = (a != 19) && (b != 19) && ((uses(a) & uses(b)) == 12'h0);
            eu1 = !e1 ? 2'd0 : (a == 3 && b == 3) ? 2'd1 : fidx(b);
            #2;
            chk(32'(issue0), 1, "R1 older issues after reset");
            chk(32'(issue1), 32'(e1), "R4 R5 R8 R10 pair issue");
            chk(32'(unit0), 32'(fidx(a)), "R3 R7 R11 older unit");
            chk(32'(unit1), 32'(eu1), "R3 R7 R11 younger unit");
            chk(32'(stall), 32'(!e1), "R9 pair stall");
         end
      end

      window(9, 10, 1, "R6 shift");
      window(10, 10, 2, "R6 mul");
      window(11, 9, 33, "R6 div");
      window(12, 10, 65, "R6 ddiv");
      window(8, 10, 0, "R6 read");
      window(7, 10, 0, "R5 write no module");
      window(13, 10, 0, "R5 fp read no module");
      window(17, 17, 14, "R7 fdiv");
      window(16, 16, 0, "R7 farith");
      window(17, 16, 0, "R7 other fpu free");
      window(19, 0, 15, "R8 block move");

      // R6 busy module blocks the younger slot too
      do_reset();
      valid0 = 1'b1; cls0 = 5'd11;
      @(negedge clk);
      cls0 = 5'd0; valid1 = 1'b1; cls1 = 5'd10;
      #2;
      chk(32'(issue0), 1, "R6 older nop issues");
      chk(32'(issue1), 0, "R6 younger mul blocked");

      // R8 younger blocked by running block move, even free class
      do_reset();
      valid0 = 1'b1; cls0 = 5'd19; valid1 = 1'b0;
      @(negedge clk);
      cls0 = 5'd3; valid1 = 1'b1; cls1 = 5'd3;
      #2;
      chk(32'(issue0), 0, "R8 older held");
      chk(32'(issue1), 0, "R8 younger held");

      // R1 reset clears a long hold
      do_reset();
      valid0 = 1'b1; valid1 = 1'b0; cls0 = 5'd12;
      repeat (5) @(negedge clk);
      cls0 = 5'd10;
      #2 chk(32'(issue0), 0, "R1 still busy before reset");
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #2 chk(32'(issue0), 1, "R1 reset frees module");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule